// File: doc/BRIEF.md
# Reset-Time Strap Configuration Capture

This block takes a snapshot of a 16-bit data bus while the chip is held in reset. The value on the bus at the last clock edge before reset is released stays in force afterwards. The captured word is decoded at once into the pin-function choices that the rest of the chip's pin multiplexing uses:

- the width of the boot chip-select;
- whether three low chip-selects act as chip-selects or as bus-arbitration signals;
- whether three more act as chip-selects or as function-code outputs;
- how many upper address lines replace the high chip-selects;
- whether the bus-control pins and the interrupt/clock-mode pins keep their normal roles or become general-purpose port pins;
- whether the factory-only slave mode is entered.

A bus bit that is left undriven reads as 1 and selects the default function.

Once reset has been released, software can replace the whole configuration word through a small write port that uses valid/ready. The port is ready whenever reset is not asserted, and a write takes effect on the next clock edge. Writes offered while reset is asserted see `wr_ready` low and are dropped. The next reset discards any software value and captures the bus again.

The block also drives an active-low enable for an external configuration driver. The enable is low only while reset is asserted, the data strobe is idle (high) and the bus is in a read cycle. This lets a pending write finish before the driver takes over the bus.

Top module: `strap_cfg`

## Requirements
- R1: While `rst_n` is low, every rising clock edge loads `bus_d` into the configuration word. After `rst_n` goes high, the word last loaded holds until a write is accepted.
- R2: `boot_wide` equals word bit 0 (1 = 16-bit boot chip-select, 0 = 8-bit).
- R3: `grp_a_cs` equals word bit 1 (1 = chip-selects, 0 = request/grant/acknowledge arbitration pins).
- R4: `grp_b_cs` equals word bit 2 (1 = chip-selects, 0 = function-code outputs).
- R5: Word bits 3..7 grade the upper address lines. `upaddr_cnt` is n+1, where n is the highest index k (0..4) with bit 3+k low, and 0 when all five bits are high. `hi_cs_keep[k]` is 1 exactly when k >= `upaddr_cnt`.
- R6: `busctl_keep` equals word bit 8 (0 = bus-control pins become port I/O).
- R7: `irq_keep` equals word bit 9 (0 = interrupt and clock-mode pins become port I/O).
- R8: `slave_en` is the inverse of word bit 11.
- R9: `drv_oe_n` is 0 exactly when `rst_n` is 0, `ds_n` is 1 and `rw` is 1. Otherwise it is 1. The output is combinational.
- R10: With `rst_n` high, `wr_ready` is 1. A cycle with `wr_valid` high loads `wr_data` into the word at that clock edge, with the same bit layout as the bus.
- R11: While `rst_n` is low, `wr_ready` is 0 and `wr_valid` has no effect. A later reset replaces any written word with the sampled bus.
- R12: Word bits 10 and 12..15 affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sampling window for the bus |
| bus_d | input | 16 | Data bus sampled during reset |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| wr_valid | input | 1 | Override write request |
| wr_ready | output | 1 | Override port can accept a write |
| wr_data | input | 16 | Override configuration word |
| boot_wide | output | 1 | Boot chip-select is 16 bits wide |
| grp_a_cs | output | 1 | Low group (0..2) stays chip-selects |
| grp_b_cs | output | 1 | Second group (3..5) stays chip-selects |
| upaddr_cnt | output | 3 | Number of upper address lines in use (0..5) |
| hi_cs_keep | output | 5 | Per high chip-select 6..10: 1 = still a chip-select |
| busctl_keep | output | 1 | Bus-control pins keep their bus role |
| irq_keep | output | 1 | Interrupt and clock-mode pins keep their role |
| slave_en | output | 1 | Factory slave mode entered |
| drv_oe_n | output | 1 | Active-low enable for the external strap driver |

## Verification
The address-grading decode is the main target. The bench uses words with one low bit, with several low bits, and with none, checking that the highest low bit wins. A decoder that let the lowest low bit win, or counted the low bits, would report too few address lines.

Directed cases cover the following:
- A write offered during reset. A design that accepted it would lose the strap value.
- A reset that follows a software override. A design that kept the override would ignore the bus.
- Words that differ only in reserved bits. These would expose a field decoded one bit off.
- Every combination of strobe, direction and reset on the driver enable. A design that dropped one qualifier would drive the bus during a write.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int WORD_W   = 16;
  localparam int NUM_HI   = 5;
  localparam int HI_BASE  = 3;
  localparam int CNT_W    = $clog2(NUM_HI + 1);

  localparam int B_BOOT   = 0;
  localparam int B_GRPA   = 1;
  localparam int B_GRPB   = 2;
  localparam int B_BUSCTL = 8;
  localparam int B_IRQ    = 9;
  localparam int B_SLAVE  = 11;

  typedef struct packed {
    logic              boot_wide;
    logic              grp_a_cs;
    logic              grp_b_cs;
    logic [CNT_W-1:0]  upaddr_cnt;
    logic [NUM_HI-1:0] hi_cs_keep;
    logic              busctl_keep;
    logic              irq_keep;
    logic              slave_en;
  } pin_sel_t;
endpackage

// File: rtl/strap_word_reg.sv
module strap_word_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_d,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word_q
);
  // Reset is a sampling window: the bus is loaded on every edge while it is low.
  always_ff @(posedge clk) begin
    if (!rst_n)       word_q <= bus_d;
    else if (wr_fire) word_q <= wr_data;
  end
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output pin_sel_t          sel
);
  logic [CNT_W-1:0]  cnt;
  logic [NUM_HI-1:0] keep;

  // Ascending scan: the highest low bit is the last to assign, so it wins.
  always_comb begin
    cnt = '0;
    for (int k = 0; k < NUM_HI; k++) begin
      if (!word[HI_BASE + k]) cnt = CNT_W'(k + 1);
    end
  end

  for (genvar k = 0; k < NUM_HI; k++) begin : g_keep
    assign keep[k] = (CNT_W'(k) >= cnt);
  end

  always_comb begin
    sel.boot_wide   = word[B_BOOT];
    sel.grp_a_cs    = word[B_GRPA];
    sel.grp_b_cs    = word[B_GRPB];
    sel.upaddr_cnt  = cnt;
    sel.hi_cs_keep  = keep;
    sel.busctl_keep = word[B_BUSCTL];
    sel.irq_keep    = word[B_IRQ];
    sel.slave_en    = ~word[B_SLAVE];
  end
endmodule

// File: rtl/strap_drv_en.sv
module strap_drv_en (
  input  logic rst_n,
  input  logic ds_n,
  input  logic rw,
  output logic drv_oe_n
);
  // Drive only in reset, with the strobe idle and the bus in a read cycle,
  // so that a write still in flight completes first.
  assign drv_oe_n = ~(~rst_n & ds_n & rw);
endmodule

// File: rtl/strap_cfg.sv
module strap_cfg
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_d,
  input  logic              ds_n,
  input  logic              rw,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              boot_wide,
  output logic              grp_a_cs,
  output logic              grp_b_cs,
  output logic [CNT_W-1:0]  upaddr_cnt,
  output logic [NUM_HI-1:0] hi_cs_keep,
  output logic              busctl_keep,
  output logic              irq_keep,
  output logic              slave_en,
  output logic              drv_oe_n
);
  logic [WORD_W-1:0] word_q;
  pin_sel_t          sel;

  assign wr_ready = rst_n;

  strap_word_reg #(.W(WORD_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_d   (bus_d),
    .wr_fire (wr_valid & wr_ready),
    .wr_data (wr_data),
    .word_q  (word_q)
  );

  strap_decode u_dec (
    .word (word_q),
    .sel  (sel)
  );

  strap_drv_en u_drv (
    .rst_n    (rst_n),
    .ds_n     (ds_n),
    .rw       (rw),
    .drv_oe_n (drv_oe_n)
  );

  assign boot_wide   = sel.boot_wide;
  assign grp_a_cs    = sel.grp_a_cs;
  assign grp_b_cs    = sel.grp_b_cs;
  assign upaddr_cnt  = sel.upaddr_cnt;
  assign hi_cs_keep  = sel.hi_cs_keep;
  assign busctl_keep = sel.busctl_keep;
  assign irq_keep    = sel.irq_keep;
  assign slave_en    = sel.slave_en;
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk
  import strap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] bus_d,
  input logic              ds_n,
  input logic              rw,
  input logic              wr_valid,
  input logic [WORD_W-1:0] wr_data,
  input logic              boot_wide,
  input logic [CNT_W-1:0]  upaddr_cnt,
  input logic [NUM_HI-1:0] hi_cs_keep,
  input logic              slave_en,
  input logic              drv_oe_n
);
  assert_capture_R1: assert property (@(posedge clk)
    !rst_n |=> (boot_wide == $past(bus_d[B_BOOT])));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(upaddr_cnt) && $stable(slave_en) && $stable(boot_wide)));

  assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hi_cs_keep) == NUM_HI - int'(upaddr_cnt));

  for (genvar k = 0; k < NUM_HI - 1; k++) begin : g_mono
    assert_thermo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hi_cs_keep[k] |-> hi_cs_keep[k+1]);
  end

  assert_oe_R9: assert property (@(posedge clk)
    !drv_oe_n |-> (!rst_n && ds_n && rw));

  assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (slave_en == !$past(wr_data[B_SLAVE])));

  assert_ignore_R11: assert property (@(posedge clk)
    (!rst_n && wr_valid) |=> (slave_en == !$past(bus_d[B_SLAVE])));
endmodule

bind strap_cfg strap_cfg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_d      (bus_d),
  .ds_n       (ds_n),
  .rw         (rw),
  .wr_valid   (wr_valid),
  .wr_data    (wr_data),
  .boot_wide  (boot_wide),
  .upaddr_cnt (upaddr_cnt),
  .hi_cs_keep (hi_cs_keep),
  .slave_en   (slave_en),
  .drv_oe_n   (drv_oe_n)
);

// File: tb/sim_strap_cfg.sv
module sim_strap_cfg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {word, expected upper-address count}
  localparam logic [18:0] VEC [NVEC] = '{
    {16'hFFFF, 3'd0}, {16'h0000, 3'd5}, {16'hFFF7, 3'd1}, {16'hFFEF, 3'd2},
    {16'hFFDF, 3'd3}, {16'hFFBF, 3'd4}, {16'hFF7F, 3'd5}, {16'hFF57, 3'd5},
    {16'hFFE7, 3'd2}, {16'hF6D5, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_d = 16'hFFFF;
  logic ds_n = 1'b1, rw = 1'b1, wr_valid = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic wr_ready, boot_wide, grp_a_cs, grp_b_cs, busctl_keep, irq_keep, slave_en, drv_oe_n;
  logic [2:0] upaddr_cnt;
  logic [4:0] hi_cs_keep;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_cfg u0 (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .ds_n(ds_n), .rw(rw),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .boot_wide(boot_wide), .grp_a_cs(grp_a_cs), .grp_b_cs(grp_b_cs),
    .upaddr_cnt(upaddr_cnt), .hi_cs_keep(hi_cs_keep), .busctl_keep(busctl_keep),
    .irq_keep(irq_keep), .slave_en(slave_en), .drv_oe_n(drv_oe_n)
  );

  function automatic logic [13:0] model(input logic [15:0] w, input logic [2:0] c);
    logic [4:0] keep;
    for (int k = 0; k < 5; k++) keep[k] = (k >= c);
    return {w[9], w[8], ~w[11], keep, c, w[2], w[1], w[0]};
  endfunction

  function automatic logic [13:0] obs();
    return {irq_keep, busctl_keep, slave_en, hi_cs_keep, upaddr_cnt, grp_b_cs, grp_a_cs, boot_wide};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Capture a word through reset, then release and let one edge pass.
  task automatic strap(input logic [15:0] w);
    @(negedge clk); rst_n = 1'b0; bus_d = w;
    @(negedge clk); rst_n = 1'b1; bus_d = ~w;
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [15:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_data = w;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 ready low in reset", {31'd0, wr_ready}, 32'd0);
    check("R1 R2 R5 reset default word", {18'd0, obs()}, {18'd0, model(16'hFFFF, 3'd0)});

    for (int i = 0; i < NVEC; i++) begin
      if (i % 2 == 0) strap(VEC[i][18:3]);
      else sw_write(VEC[i][18:3]);
      check("R1 R2 R3 R4 R5 R6 R7 R8 R10 decode", {18'd0, obs()},
            {18'd0, model(VEC[i][18:3], VEC[i][2:0])});
    end

    // R1: the held word ignores bus changes after release
    strap(16'hFFFE);
    bus_d = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 hold after release", {18'd0, obs()}, {18'd0, model(16'hFFFE, 3'd0)});

    // R11: write during reset is dropped
    @(negedge clk); rst_n = 1'b0; bus_d = 16'hF7FF; wr_valid = 1'b1; wr_data = 16'h0000;
    @(negedge clk); wr_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R11 write in reset ignored", {18'd0, obs()}, {18'd0, model(16'hF7FF, 3'd0)});

    // R11: new reset discards an override
    sw_write(16'h0000);
    check("R10 override applied", {31'd0, slave_en}, 32'd1);
    strap(16'hFFFF);
    check("R11 reset discards override", {18'd0, obs()}, {18'd0, model(16'hFFFF, 3'd0)});

    // R12: reserved bits
    sw_write(16'h0BFF);
    check("R12 reserved bits ignored", {18'd0, obs()}, {18'd0, model(16'hFFFF, 3'd0)});

    // R9: driver enable over all qualifier combinations
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      rst_n = m[2]; ds_n = m[1]; rw = m[0];
      #1;
      check("R9 driver enable", {31'd0, drv_oe_n}, {31'd0, !(m == 3)});
    end
    rst_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule